// File: doc/BRIEF.md
# Coprocessor Command Front-End with Local Result File

This block sits between a host core and a set of single-precision arithmetic units. The host offers one 32-bit custom instruction together with two 64-bit source words through a valid/ready handshake. On acceptance the block captures the instruction and the four 32-bit operands carried in the source words, checks that the command is well formed, and issues the selected operation to an execution port as a one-cycle start pulse.

The block then waits for the execution unit to return a one-cycle done pulse with a 32-bit result. It writes that result into a private 32-entry register file at the destination index taken from the instruction. The host gets no response. Ready stays low for the whole time a legal command is in flight. A malformed command is taken off the bus and discarded. A combinational debug port lets any entry of the register file be read back.

Top module: `cop_frontend`

## Requirements
- R1: While rst_n is low at a rising clock edge, the block is reset synchronously. After that edge cmd_ready is 1, eu_start is 0 and every register file entry reads 0 on the debug port.
- R2: The instruction fields sit at these bit positions: opcode in bits 6:5, rd in 11:7, xs2 in bit 12, xs1 in 13, xd in 14, rs1 in 19:15, rs2 in 24:20 and funct7 in 31:25. Bits 4:0 are don't-care. A command is legal only when all of the following hold: opcode is 0, xd is 0, xs1 is 1, xs2 is 1, rs1 is 0, rs2 is 1, and funct7 is 1, 2 or 3.
- R3: A command is accepted at a rising edge where cmd_valid and cmd_ready are both 1. After a legal acceptance, cmd_ready is 0 from the next cycle and stays 0 until the edge that samples eu_done.
- R4: The operands leave the block in this order. eu_opnd_a carries src_a[63:32], eu_opnd_b carries src_a[31:0], eu_opnd_c carries src_b[63:32] and eu_opnd_d carries src_b[31:0].
- R5: In the cycle after a legal acceptance, eu_start is 1 for exactly one cycle. In that cycle eu_op carries funct7[1:0]: 1 selects a*b+c*d, 2 selects a/b+c/d, and 3 selects the third operation.
- R6: At the rising edge where eu_done is sampled while a command waits, eu_result is written to entry rd. From the next cycle the written value reads back on the debug port and cmd_ready is 1.
- R7: An illegal command is accepted and then discarded. No start pulse is issued, no entry is written, and cmd_ready is 1 in the next cycle.
- R8: The instruction and operands are captured at acceptance. Changing cmd_inst, cmd_src_a or cmd_src_b afterwards has no effect on eu_op, the operands or the destination entry.
- R9: An eu_done pulse that arrives while no command is waiting is ignored. No entry changes and cmd_ready stays 1.
- R10: dbg_data shows the entry selected by dbg_addr in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Host offers a command |
| cmd_ready | output | 1 | Block can accept a command |
| cmd_inst | input | 32 | Custom instruction word |
| cmd_src_a | input | 64 | First source word (operands a, b) |
| cmd_src_b | input | 64 | Second source word (operands c, d) |
| eu_start | output | 1 | One-cycle issue pulse to execution unit |
| eu_op | output | 2 | Operation select, funct7[1:0] |
| eu_opnd_a | output | 32 | Operand a |
| eu_opnd_b | output | 32 | Operand b |
| eu_opnd_c | output | 32 | Operand c |
| eu_opnd_d | output | 32 | Operand d |
| eu_done | input | 1 | One-cycle completion pulse |
| eu_result | input | 32 | Result presented with eu_done |
| dbg_addr | input | 5 | Debug read index |
| dbg_data | output | 32 | Debug read data |

## Verification
The bound assertions are checked on every cycle. They cover the handshake sequencing: ready falls after a legal acceptance, the start pulse follows one cycle later and lasts one cycle, an illegal acceptance leaves ready high with no start, the operand and op outputs hold while a command waits, and a stray done is ignored. What only the bench scenarios can show is data correctness. They show that each operand lands on the right port after the host has scrambled its inputs, that the returned value reaches exactly entry rd (including indices 0 and 31), and that illegal commands leave earlier contents untouched. They also show that ready stays low for exactly the execution latency and that a mid-run reset clears every entry.

// File: rtl/cop_pkg.sv
package cop_pkg;
   typedef struct packed {
      logic [6:0] funct7;
      logic [4:0] rs2;
      logic [4:0] rs1;
      logic       xd;
      logic       xs1;
      logic       xs2;
      logic [4:0] rd;
      logic [1:0] opcode;
      logic [4:0] spare;
   } cop_inst_t;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ISSUE = 2'd1,
      ST_WAIT  = 2'd2
   } cop_state_e;

   localparam logic [6:0] FN_MULADD = 7'd1;
   localparam logic [6:0] FN_DIVADD = 7'd2;
   localparam logic [6:0] FN_THIRD  = 7'd3;
   localparam logic [4:0] RS1_FIXED = 5'd0;
   localparam logic [4:0] RS2_FIXED = 5'd1;
endpackage

// File: rtl/cop_decode.sv
module cop_decode
   import cop_pkg::*;
#(
   parameter bit CHECK_RS_FIELDS = 1'b1
) (
   input  cop_inst_t  inst,
   output logic       legal,
   output logic [1:0] op_sel
);
   logic regs_ok;
   logic ctl_ok;
   logic fn_ok;

   generate
      if (CHECK_RS_FIELDS) begin : g_rs_chk
         assign regs_ok = (inst.rs1 == RS1_FIXED) && (inst.rs2 == RS2_FIXED);
      end else begin : g_rs_free
         assign regs_ok = 1'b1;
      end
   endgenerate

   always_comb begin
      ctl_ok = (inst.opcode == 2'd0) && !inst.xd && inst.xs1 && inst.xs2;
      fn_ok  = (inst.funct7 == FN_MULADD) || (inst.funct7 == FN_DIVADD) ||
               (inst.funct7 == FN_THIRD);
      legal  = ctl_ok && fn_ok && regs_ok;
      op_sel = inst.funct7[1:0];
   end
endmodule

// File: rtl/cop_ctrl.sv
module cop_ctrl
   import cop_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic cmd_valid,
   input  logic legal,
   input  logic eu_done,
   output logic cmd_ready,
   output logic cap_en,
   output logic eu_start,
   output logic wr_en
);
   cop_state_e state_q, state_d;
   logic       fire;

   always_comb begin
      cmd_ready = (state_q == ST_IDLE);
      fire      = cmd_valid && cmd_ready;
      cap_en    = fire && legal;
      eu_start  = (state_q == ST_ISSUE);
      wr_en     = (state_q == ST_WAIT) && eu_done;
      state_d   = state_q;
      unique case (state_q)
         ST_IDLE:  if (cap_en) state_d = ST_ISSUE;
         ST_ISSUE: state_d = ST_WAIT;
         ST_WAIT:  if (eu_done) state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end
endmodule

// File: rtl/cop_regfile.sv
module cop_regfile #(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem_q [DEPTH];

   generate
      for (genvar e = 0; e < DEPTH; e++) begin : g_entry
         always_ff @(posedge clk) begin
            if (!rst_n)
               mem_q[e] <= '0;
            else if (wr_en && (wr_addr == ADDR_W'(e)))
               mem_q[e] <= wr_data;
         end
      end
   endgenerate

   assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/cop_frontend.sv
module cop_frontend
   import cop_pkg::*;
#(
   parameter int DATA_W          = 32,
   parameter int RF_AW           = 5,
   parameter bit CHECK_RS_FIELDS = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cmd_valid,
   output logic                cmd_ready,
   input  logic [31:0]         cmd_inst,
   input  logic [2*DATA_W-1:0] cmd_src_a,
   input  logic [2*DATA_W-1:0] cmd_src_b,
   output logic                eu_start,
   output logic [1:0]          eu_op,
   output logic [DATA_W-1:0]   eu_opnd_a,
   output logic [DATA_W-1:0]   eu_opnd_b,
   output logic [DATA_W-1:0]   eu_opnd_c,
   output logic [DATA_W-1:0]   eu_opnd_d,
   input  logic                eu_done,
   input  logic [DATA_W-1:0]   eu_result,
   input  logic [RF_AW-1:0]    dbg_addr,
   output logic [DATA_W-1:0]   dbg_data
);
   localparam int SRC_W  = 2 * DATA_W;
   localparam int N_OPND = 4;

   generate
      if (DATA_W != 32) begin : g_bad_width
         $error("cop_frontend: operands are single precision, DATA_W must be 32");
      end
      if (RF_AW < 1 || RF_AW > 5) begin : g_bad_aw
         $error("cop_frontend: RF_AW must fit the 5-bit rd field");
      end
   endgenerate

   cop_inst_t         inst_w;
   logic              legal;
   logic [1:0]        op_sel;
   logic              cap_en;
   logic              wr_en;
   logic [1:0]        op_q;
   logic [RF_AW-1:0]  rd_q;
   logic [DATA_W-1:0] opnd_in [N_OPND];
   logic [DATA_W-1:0] opnd_q  [N_OPND];

   assign inst_w = cop_inst_t'(cmd_inst);

   cop_decode #(.CHECK_RS_FIELDS(CHECK_RS_FIELDS)) u_dec (
      .inst   (inst_w),
      .legal  (legal),
      .op_sel (op_sel)
   );

   cop_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .legal     (legal),
      .eu_done   (eu_done),
      .cmd_ready (cmd_ready),
      .cap_en    (cap_en),
      .eu_start  (eu_start),
      .wr_en     (wr_en)
   );

   // lane 2k+0 takes the upper half of word k, lane 2k+1 the lower half
   generate
      for (genvar k = 0; k < N_OPND; k++) begin : g_lane
         localparam int HI = (k % 2 == 0) ? SRC_W - 1 : DATA_W - 1;
         if (k < 2) begin : g_src_a
            assign opnd_in[k] = cmd_src_a[HI -: DATA_W];
         end else begin : g_src_b
            assign opnd_in[k] = cmd_src_b[HI -: DATA_W];
         end
         always_ff @(posedge clk) begin
            if (!rst_n)      opnd_q[k] <= '0;
            else if (cap_en) opnd_q[k] <= opnd_in[k];
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         op_q <= '0;
         rd_q <= '0;
      end else if (cap_en) begin
         op_q <= op_sel;
         rd_q <= inst_w.rd[RF_AW-1:0];
      end
   end

   assign eu_op     = op_q;
   assign eu_opnd_a = opnd_q[0];
   assign eu_opnd_b = opnd_q[1];
   assign eu_opnd_c = opnd_q[2];
   assign eu_opnd_d = opnd_q[3];

   cop_regfile #(.DATA_W(DATA_W), .ADDR_W(RF_AW)) u_rf (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (rd_q),
      .wr_data (eu_result),
      .rd_addr (dbg_addr),
      .rd_data (dbg_data)
   );
endmodule

// File: rtl/cop_frontend_chk.sv
module cop_frontend_chk
   import cop_pkg::*;
#(
   parameter int DATA_W          = 32,
   parameter bit CHECK_RS_FIELDS = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_valid,
   input logic              cmd_ready,
   input logic [31:0]       cmd_inst,
   input logic              eu_start,
   input logic [1:0]        eu_op,
   input logic [DATA_W-1:0] eu_opnd_a,
   input logic [DATA_W-1:0] eu_opnd_b,
   input logic [DATA_W-1:0] eu_opnd_c,
   input logic [DATA_W-1:0] eu_opnd_d,
   input logic              eu_done
);
   cop_inst_t ci;
   logic      ok_cmd;
   logic      fire;

   assign ci     = cop_inst_t'(cmd_inst);
   assign ok_cmd = (ci.opcode == 2'd0) && !ci.xd && ci.xs1 && ci.xs2 &&
                   (ci.funct7 >= 7'd1) && (ci.funct7 <= 7'd3) &&
                   (!CHECK_RS_FIELDS || (ci.rs1 == 5'd0 && ci.rs2 == 5'd1));
   assign fire   = cmd_valid && cmd_ready;

   p_reset_ready_r1: assert property (@(posedge clk) !rst_n |=> cmd_ready && !eu_start);

   p_busy_after_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && ok_cmd) |=> !cmd_ready);

   p_start_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      eu_start |-> !cmd_ready);

   p_start_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && ok_cmd) |=> eu_start);

   p_start_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      eu_start |=> !eu_start);

   p_release_on_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!cmd_ready && !eu_start && eu_done) |=> cmd_ready);

   p_drop_illegal_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !ok_cmd) |=> (cmd_ready && !eu_start));

   p_hold_operands_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!cmd_ready && !eu_done) |=> ($stable(eu_op) && $stable(eu_opnd_a) &&
         $stable(eu_opnd_b) && $stable(eu_opnd_c) && $stable(eu_opnd_d)));

   p_stray_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_ready && !cmd_valid && eu_done) |=> (cmd_ready && !eu_start));
endmodule

bind cop_frontend cop_frontend_chk #(
   .DATA_W          (DATA_W),
   .CHECK_RS_FIELDS (CHECK_RS_FIELDS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_valid (cmd_valid),
   .cmd_ready (cmd_ready),
   .cmd_inst  (cmd_inst),
   .eu_start  (eu_start),
   .eu_op     (eu_op),
   .eu_opnd_a (eu_opnd_a),
   .eu_opnd_b (eu_opnd_b),
   .eu_opnd_c (eu_opnd_c),
   .eu_opnd_d (eu_opnd_d),
   .eu_done   (eu_done)
);

// File: tb/cop_frontend_tb_top.sv
module cop_frontend_tb_top;
   typedef struct packed {
      logic [1:0]  op;
      logic [31:0] a;
      logic [31:0] b;
      logic [31:0] c;
      logic [31:0] d;
   } issue_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic        cmd_ready;
   logic [31:0] cmd_inst = '0;
   logic [63:0] cmd_src_a = '0;
   logic [63:0] cmd_src_b = '0;
   logic        eu_start;
   logic [1:0]  eu_op;
   logic [31:0] eu_opnd_a, eu_opnd_b, eu_opnd_c, eu_opnd_d;
   logic        eu_done;
   logic [31:0] eu_result;
   logic [4:0]  dbg_addr = '0;
   logic [31:0] dbg_data;

   logic        m_done = 1'b0;
   logic [31:0] m_res = '0;
   logic        stray_done = 1'b0;
   logic [31:0] stray_val = '0;

   int          n_cmp = 0;
   int          n_bad = 0;
   int          lat = 2;
   issue_t      exp_q[$];
   logic [31:0] rf_model [32];

   always #2 clk = ~clk;

   assign eu_done   = m_done | stray_done;
   assign eu_result = stray_done ? stray_val : m_res;

   cop_frontend dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_inst(cmd_inst), .cmd_src_a(cmd_src_a), .cmd_src_b(cmd_src_b),
      .eu_start(eu_start), .eu_op(eu_op), .eu_opnd_a(eu_opnd_a),
      .eu_opnd_b(eu_opnd_b), .eu_opnd_c(eu_opnd_c), .eu_opnd_d(eu_opnd_d),
      .eu_done(eu_done), .eu_result(eu_result), .dbg_addr(dbg_addr),
      .dbg_data(dbg_data)
   );

   function automatic logic [31:0] eu_calc(issue_t it);
      return {30'd0, it.op} * 32'h0101_0101 ^ it.a ^ {it.b[30:0], it.b[31]} ^
             {it.c[29:0], it.c[31:30]} ^ ~it.d;
   endfunction

   function automatic logic [31:0] mk(logic [6:0] f7, logic [4:0] rd,
                                      logic [1:0] opc = 2'd0, logic xd = 1'b0,
                                      logic xs1 = 1'b1, logic xs2 = 1'b1,
                                      logic [4:0] rs1 = 5'd0, logic [4:0] rs2 = 5'd1);
      return {f7, rs2, rs1, xd, xs1, xs2, rd, opc, 5'h1b};
   endfunction

   task automatic check(string req, logic [63:0] act, logic [63:0] exp, string what);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // monitor / execution-unit model: pops expected issues, answers after lat cycles
   initial begin
      forever begin
         @(negedge clk);
         if (eu_start) begin
            if (exp_q.size() == 0) begin
               n_cmp++; n_bad++;
               $display("FAIL R7 unexpected start: actual 1 expected 0");
            end else begin
               issue_t e;
               issue_t got;
               e   = exp_q.pop_front();
               got = '{op: eu_op, a: eu_opnd_a, b: eu_opnd_b, c: eu_opnd_c, d: eu_opnd_d};
               check("R5", {62'd0, got.op}, {62'd0, e.op}, "eu_op");
               check("R4", {got.a, got.b}, {e.a, e.b}, "operands a,b");
               check("R4", {got.c, got.d}, {e.c, e.d}, "operands c,d");
               for (int w = 1; w < lat; w++) begin
                  @(negedge clk);
                  if (w == 1) check("R5", {63'd0, eu_start}, 64'd0, "start width");
               end
               m_res  = eu_calc(e);
               m_done = 1'b1;
               @(negedge clk);
               m_done = 1'b0;
            end
         end
      end
   end

   task automatic send(logic [31:0] inst, logic [63:0] sa, logic [63:0] sb,
                       bit legal, int l, string tag);
      issue_t it;
      logic [4:0] rd = inst[11:7];
      int cyc = 0;
      it = '{op: inst[26:25], a: sa[63:32], b: sa[31:0], c: sb[63:32], d: sb[31:0]};
      lat = l;
      if (legal) exp_q.push_back(it);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_inst = inst; cmd_src_a = sa; cmd_src_b = sb;
      @(negedge clk);
      cmd_valid = 1'b0; cmd_inst = ~inst; cmd_src_a = ~sa; cmd_src_b = ~sb;
      if (legal) begin
         check("R3", {63'd0, cmd_ready}, 64'd0, {tag, " ready after accept"});
         check("R5", {63'd0, eu_start}, 64'd1, {tag, " start after accept"});
         while (!cmd_ready && cyc < 100) begin
            @(negedge clk);
            cyc++;
         end
         check("R3", 64'(cyc), 64'(l), {tag, " busy cycles"});
         rf_model[rd] = eu_calc(it);
      end else begin
         check("R7", {63'd0, cmd_ready}, 64'd1, {tag, " ready after drop"});
      end
      dbg_addr = rd;
      #1;
      check(legal ? "R6" : "R7", {32'd0, dbg_data}, {32'd0, rf_model[rd]}, {tag, " entry"});
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      check("R1", {62'd0, cmd_ready, eu_start}, 64'd2, "ready/start in reset");
      rst_n = 1'b1;
      for (int i = 0; i < 32; i++) rf_model[i] = '0;
      begin
         int nz = 0;
         for (int i = 0; i < 32; i++) begin
            dbg_addr = 5'(i);
            #0.1;
            if (dbg_data !== 32'd0) nz++;
         end
         check("R1", 64'(nz), 64'd0, "nonzero entries after reset");
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      do_reset();
      send(mk(7'd1, 5'd5),  64'h3f80_0000_4000_0000, 64'h4040_0000_4080_0000, 1, 2, "R2 muladd rd5");
      send(mk(7'd2, 5'd31), 64'hc120_0000_3f00_0000, 64'h4110_0000_bf80_0000, 1, 5, "R2 divadd rd31");
      send(mk(7'd3, 5'd0),  64'h1234_5678_9abc_def0, 64'h0f0f_0f0f_f0f0_f0f0, 1, 3, "R2 third rd0");
      send(mk(7'd0, 5'd7),  64'h1, 64'h2, 0, 2, "R7 funct7=0");
      send(mk(7'd4, 5'd5),  64'h3, 64'h4, 0, 2, "R7 funct7=4");
      send(mk(7'd1, 5'd5, 2'd1), 64'h5, 64'h6, 0, 2, "R7 opcode=1");
      send(mk(7'd1, 5'd31, 2'd0, 1'b1), 64'h7, 64'h8, 0, 2, "R7 xd=1");
      send(mk(7'd2, 5'd0, 2'd0, 1'b0, 1'b0), 64'h9, 64'ha, 0, 2, "R7 xs1=0");
      send(mk(7'd2, 5'd0, 2'd0, 1'b0, 1'b1, 1'b0), 64'hb, 64'hc, 0, 2, "R7 xs2=0");
      send(mk(7'd3, 5'd5, 2'd0, 1'b0, 1'b1, 1'b1, 5'd0, 5'd2), 64'hd, 64'he, 0, 2, "R7 rs2=2");
      send(mk(7'd2, 5'd5),  64'hdead_beef_cafe_f00d, 64'h0123_4567_89ab_cdef, 1, 4, "R8 overwrite rd5");
      // R9: stray completion while idle
      dbg_addr = 5'd5;
      @(negedge clk);
      stray_val = 32'h5555_aaaa; stray_done = 1'b1;
      @(negedge clk);
      stray_done = 1'b0;
      check("R9", {63'd0, cmd_ready}, 64'd1, "ready after stray done");
      #1;
      check("R9", {32'd0, dbg_data}, {32'd0, rf_model[5]}, "entry 5 after stray done");
      // R10: debug read follows address without a clock edge
      dbg_addr = 5'd31;
      #0.5;
      check("R10", {32'd0, dbg_data}, {32'd0, rf_model[31]}, "same-cycle read");
      do_reset();
      send(mk(7'd1, 5'd12), 64'h4120_0000_c0a0_0000, 64'h3e80_0000_4200_0000, 1, 2, "R6 after reset rd12");
      repeat (3) @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule